// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight token flags that two independent ports, called left and right, share to implement software mutual exclusion. A port reaches the bank by asserting its semaphore select (low) while its memory enable is inactive (high). It picks a flag with a 3-bit index, asks for a flag by writing 0 on its single write-data bit, and gives it back by writing 1. A read returns the flag's status replicated on all 16 read-data bits. The value 0 means the reading port holds the token, and 1 means it does not.

Each flag also remembers one pending request from the port that does not hold the token. When the owner releases the flag, the token passes straight to the waiting port with no second request. The waiting port can withdraw its request by writing 1. Reads are combinational views of the registered flag state. A write takes effect at the next rising clock edge.

Top module: `semaphore_bank`

## Requirements
- R1: After reset, all eight flags are free with nothing pending, so every read on either port returns 16'hFFFF.
- R2: A port accesses the bank only when its memory enable is 1 and its semaphore select is 0. At any other time its writes change no flag and its read data is 16'h0000. A write cycle also returns 16'h0000.
- R3: A read returns one status bit on all 16 data bits: 16'h0000 when the reading port holds the selected flag, and 16'hFFFF otherwise. The read shows the state before the current clock edge, and a write becomes visible in the next cycle.
- R4: Writing 0 to a free flag grants it to the writer. Afterwards the writer reads 0 and the other port reads 1. The two ports never both read 0 for the same flag.
- R5: Writing 0 to a flag that the other port holds leaves the token in place, and the requester keeps reading 1. The request is recorded as pending.
- R6: When the owner writes 1 and a request from the other port is pending, or is being written in the same cycle, the token passes directly to the other port.
- R7: When the owner writes 1 and no request is pending, the flag becomes free and both ports read 1.
- R8: When the port that does not hold the token writes 1, any pending request it has is cancelled. A later release by the owner then frees the flag.
- R9: When both ports write 0 to the same free flag in one cycle, the left port is granted the token and the right port's request is recorded as pending.
- R10: Flags are independent: an access to one index never changes another flag.
- R11: The owner writing 0 again, and any port writing 1 to a free flag, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| lMemEnN | input | 1 | Left memory enable, active low; must be 1 for a bank access |
| lSemSelN | input | 1 | Left semaphore select, active low |
| lWrN | input | 1 | Left write strobe, active low; 1 means read |
| lIdx | input | 3 | Left flag index |
| lWrBit | input | 1 | Left write data: 0 requests, 1 releases or cancels |
| lRdData | output | 16 | Left read data, status replicated |
| rMemEnN | input | 1 | Right memory enable, active low |
| rSemSelN | input | 1 | Right semaphore select, active low |
| rWrN | input | 1 | Right write strobe, active low |
| rIdx | input | 3 | Right flag index |
| rWrBit | input | 1 | Right write data |
| rRdData | output | 16 | Right read data, status replicated |

## Verification
A wrong owner register appears in the very next read of that index. It shows either as two ports both reading 0, or as a port still reading 1 after a grant it should have received. A wrong pending bit is invisible until the owner releases the flag. The flag then becomes free when it should have moved to the other port, or the reverse, so the bench keeps random traffic on a few indices to make releases follow requests closely. A decode fault that hits the wrong index only shows when the bank later reads that other flag.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } semOwner_t;

  // per-flag strobes from a port's control to the flag datapath
  typedef struct packed {
    logic req;   // write of 0 to this flag
    logic rel;   // write of 1 to this flag
  } semStrobe_t;

endpackage

// File: rtl/sem_port_ctrl.sv
module sem_port_ctrl
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic                   memEnN,
  input  logic                   semSelN,
  input  logic                   wrN,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   wrBit,
  output semStrobe_t [NUM_FLAGS-1:0] stb,
  output logic                   rdEn
);

  logic access;
  logic wrAccess;

  always_comb begin
    access   = memEnN && !semSelN;
    wrAccess = access && !wrN;
    rdEn     = access && wrN;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : gDec
    logic hit;
    always_comb begin
      hit        = wrAccess && (idx == IDX_W'(f));
      stb[f].req = hit && !wrBit;
      stb[f].rel = hit && wrBit;
    end
  end

endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  semStrobe_t [NUM_FLAGS-1:0] lStb,
  input  semStrobe_t [NUM_FLAGS-1:0] rStb,
  input  logic                       lRdEn,
  input  logic                       rRdEn,
  input  logic [IDX_W-1:0]           lIdx,
  input  logic [IDX_W-1:0]           rIdx,
  output logic [DATA_W-1:0]          lRdData,
  output logic [DATA_W-1:0]          rRdData
);

  logic [NUM_FLAGS-1:0] lHeld;
  logic [NUM_FLAGS-1:0] rHeld;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : gFlag
    semOwner_t owner, ownerNxt;
    logic      pend, pendNxt;
    logic      waitNxt;

    always_comb begin
      ownerNxt = owner;
      pendNxt  = pend;
      waitNxt  = pend;
      unique case (owner)
        OWN_FREE: begin
          if (lStb[f].req) begin
            ownerNxt = OWN_LEFT;      // left wins a tie
            pendNxt  = rStb[f].req;
          end else if (rStb[f].req) begin
            ownerNxt = OWN_RIGHT;
            pendNxt  = 1'b0;
          end
        end
        OWN_LEFT: begin
          if (rStb[f].req)      waitNxt = 1'b1;
          else if (rStb[f].rel) waitNxt = 1'b0;
          if (lStb[f].rel) begin
            ownerNxt = waitNxt ? OWN_RIGHT : OWN_FREE;
            pendNxt  = 1'b0;
          end else begin
            pendNxt  = waitNxt;
          end
        end
        OWN_RIGHT: begin
          if (lStb[f].req)      waitNxt = 1'b1;
          else if (lStb[f].rel) waitNxt = 1'b0;
          if (rStb[f].rel) begin
            ownerNxt = waitNxt ? OWN_LEFT : OWN_FREE;
            pendNxt  = 1'b0;
          end else begin
            pendNxt  = waitNxt;
          end
        end
        default: begin
          ownerNxt = OWN_FREE;
          pendNxt  = 1'b0;
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        owner <= OWN_FREE;
        pend  <= 1'b0;
      end else begin
        owner <= ownerNxt;
        pend  <= pendNxt;
      end
    end

    assign lHeld[f] = (owner == OWN_LEFT);
    assign rHeld[f] = (owner == OWN_RIGHT);
  end

  logic lStat, rStat;

  always_comb begin
    lStat   = !lHeld[lIdx];
    rStat   = !rHeld[rIdx];
    lRdData = lRdEn ? {DATA_W{lStat}} : '0;
    rRdData = rRdEn ? {DATA_W{rStat}} : '0;
  end

endmodule

// File: rtl/semaphore_bank.sv
module semaphore_bank
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lMemEnN,
  input  logic              lSemSelN,
  input  logic              lWrN,
  input  logic [IDX_W-1:0]  lIdx,
  input  logic              lWrBit,
  output logic [DATA_W-1:0] lRdData,
  input  logic              rMemEnN,
  input  logic              rSemSelN,
  input  logic              rWrN,
  input  logic [IDX_W-1:0]  rIdx,
  input  logic              rWrBit,
  output logic [DATA_W-1:0] rRdData
);

  semStrobe_t [NUM_FLAGS-1:0] lStb, rStb;
  logic lRdEn, rRdEn;

  sem_port_ctrl #(.NUM_FLAGS(NUM_FLAGS)) uLeftCtrl (
    .memEnN(lMemEnN), .semSelN(lSemSelN), .wrN(lWrN), .idx(lIdx),
    .wrBit(lWrBit), .stb(lStb), .rdEn(lRdEn)
  );

  sem_port_ctrl #(.NUM_FLAGS(NUM_FLAGS)) uRightCtrl (
    .memEnN(rMemEnN), .semSelN(rSemSelN), .wrN(rWrN), .idx(rIdx),
    .wrBit(rWrBit), .stb(rStb), .rdEn(rRdEn)
  );

  sem_flag_bank #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) uBank (
    .clk(clk), .rstN(rstN),
    .lStb(lStb), .rStb(rStb), .lRdEn(lRdEn), .rRdEn(rRdEn),
    .lIdx(lIdx), .rIdx(rIdx), .lRdData(lRdData), .rRdData(rRdData)
  );

endmodule

// File: rtl/semaphore_bank_checker.sv
module semaphore_bank_checker #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              lMemEnN,
  input logic              lSemSelN,
  input logic              lWrN,
  input logic [IDX_W-1:0]  lIdx,
  input logic              lWrBit,
  input logic [DATA_W-1:0] lRdData,
  input logic              rMemEnN,
  input logic              rSemSelN,
  input logic              rWrN,
  input logic [IDX_W-1:0]  rIdx,
  input logic [DATA_W-1:0] rRdData
);

  logic lAcc, rAcc, lRd, rRd, lWr, rWr, lReq0;
  always_comb begin
    lAcc  = lMemEnN && !lSemSelN;
    rAcc  = rMemEnN && !rSemSelN;
    lRd   = lAcc && lWrN;
    rRd   = rAcc && rWrN;
    lWr   = lAcc && !lWrN;
    rWr   = rAcc && !rWrN;
    lReq0 = lWr && !lWrBit;
  end

  // R2: no read access means quiet data
  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lRd |-> lRdData == '0);

  // R3: status replicated on all bits
  p_replicate_r3: assert property (@(posedge clk) disable iff (!rstN)
    rRd |-> (rRdData == '0 || rRdData == '1));

  // R4: mutual exclusion
  p_mutex_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lRd && rRd && lIdx == rIdx) |-> !(lRdData[0] == 1'b0 && rRdData[0] == 1'b0));

  // R4: a left request while the right port reads "not held" yields a grant
  p_grant_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lReq0 && rRd && rIdx == lIdx && rRdData[0]) |=> (lRd && lIdx == $past(lIdx)) |-> lRdData == '0);

  // R5/R10: without any write, a repeated read is unchanged
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!lWr && !rWr && lRd) |=> (lRd && lIdx == $past(lIdx)) |-> lRdData == $past(lRdData));

endmodule

bind semaphore_bank semaphore_bank_checker #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN),
  .lMemEnN(lMemEnN), .lSemSelN(lSemSelN), .lWrN(lWrN), .lIdx(lIdx),
  .lWrBit(lWrBit), .lRdData(lRdData),
  .rMemEnN(rMemEnN), .rSemSelN(rSemSelN), .rWrN(rWrN), .rIdx(rIdx),
  .rRdData(rRdData)
);

// File: tb/tb_semaphore_bank.sv
module tb_semaphore_bank;

  localparam int NF = 8;
  localparam int DW = 16;

  // op kinds
  localparam int K_IDLE = 0, K_RD = 1, K_WR = 2, K_WR_MEM = 3, K_WR_NOSEL = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic lMemEnN, lSemSelN, lWrN, lWrBit, rMemEnN, rSemSelN, rWrN, rWrBit;
  logic [2:0] lIdx, rIdx;
  logic [DW-1:0] lRdData, rRdData;

  int total = 0, bad = 0;
  int own [NF];   // 0 free, 1 left, 2 right
  bit pend [NF];
  int lKind, rKind;

  always #4 clk = ~clk;

  semaphore_bank dut (
    .clk(clk), .rstN(rstN),
    .lMemEnN(lMemEnN), .lSemSelN(lSemSelN), .lWrN(lWrN), .lIdx(lIdx),
    .lWrBit(lWrBit), .lRdData(lRdData),
    .rMemEnN(rMemEnN), .rSemSelN(rSemSelN), .rWrN(rWrN), .rIdx(rIdx),
    .rWrBit(rWrBit), .rRdData(rRdData)
  );

  task automatic setPort(input bit left, input int kind, input int idx, input bit b);
    logic me, ss, wn;
    me = 1'b1; ss = 1'b0; wn = 1'b1;
    case (kind)
      K_IDLE:     begin me = 1'b1; ss = 1'b1; end
      K_RD:       ;
      K_WR:       wn = 1'b0;
      K_WR_MEM:   begin me = 1'b0; wn = 1'b0; end
      default:    begin ss = 1'b1; wn = 1'b0; end
    endcase
    if (left) begin
      lKind = kind; lMemEnN = me; lSemSelN = ss; lWrN = wn; lIdx = 3'(idx); lWrBit = b;
    end else begin
      rKind = kind; rMemEnN = me; rSemSelN = ss; rWrN = wn; rIdx = 3'(idx); rWrBit = b;
    end
  endtask

  function automatic logic [DW-1:0] expRd(input int kind, input int idx, input int me);
    if (kind != K_RD) return '0;
    return (own[idx] == me) ? '0 : '1;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelUpdate();
    for (int f = 0; f < NF; f++) begin
      bit lw, lv, rw, rv, w;
      lw = (lKind == K_WR) && (lIdx == 3'(f)); lv = lWrBit;
      rw = (rKind == K_WR) && (rIdx == 3'(f)); rv = rWrBit;
      case (own[f])
        0: if (lw && !lv) begin own[f] = 1; pend[f] = rw && !rv; end
           else if (rw && !rv) begin own[f] = 2; pend[f] = 0; end
        1: begin
             w = rw ? !rv : pend[f];
             if (lw && lv) begin own[f] = w ? 2 : 0; pend[f] = 0; end
             else pend[f] = w;
           end
        default: begin
             w = lw ? !lv : pend[f];
             if (rw && rv) begin own[f] = w ? 1 : 0; pend[f] = 0; end
             else pend[f] = w;
           end
      endcase
    end
  endtask

  // inputs already set after a negedge; check reads, clock, update model
  task automatic step(input string tag);
    #1;
    chk({tag, " left"},  lRdData, expRd(lKind, int'(lIdx), 1));
    chk({tag, " right"}, rRdData, expRd(rKind, int'(rIdx), 2));
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic op(input string tag, input int lk, input int li, input bit lb,
                    input int rk, input int ri, input bit rb);
    setPort(1'b1, lk, li, lb);
    setPort(1'b0, rk, ri, rb);
    step(tag);
  endtask

  task automatic readBoth(input string tag, input int idx);
    op(tag, K_RD, idx, 1'b0, K_RD, idx, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int f = 0; f < NF; f++) begin own[f] = 0; pend[f] = 0; end
    setPort(1'b1, K_IDLE, 0, 1'b0);
    setPort(1'b0, K_IDLE, 0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: everything free after reset
    for (int f = 0; f < NF; f++) readBoth("R1", f);

    // procurement sequence on flag 3
    op("R4", K_WR, 3, 1'b0, K_IDLE, 0, 1'b0); readBoth("R4", 3);
    op("R5", K_IDLE, 0, 1'b0, K_WR, 3, 1'b0); readBoth("R5", 3);
    op("R6", K_WR, 3, 1'b1, K_IDLE, 0, 1'b0); readBoth("R6", 3);
    op("R5", K_WR, 3, 1'b0, K_IDLE, 0, 1'b0); readBoth("R5", 3);
    op("R6", K_IDLE, 0, 1'b0, K_WR, 3, 1'b1); readBoth("R6", 3);
    op("R7", K_WR, 3, 1'b1, K_IDLE, 0, 1'b0); readBoth("R7", 3);
    op("R4", K_IDLE, 0, 1'b0, K_WR, 3, 1'b0); readBoth("R4", 3);
    op("R7", K_IDLE, 0, 1'b0, K_WR, 3, 1'b1); readBoth("R7", 3);

    // R8: cancel a pending request
    op("R8", K_WR, 5, 1'b0, K_IDLE, 0, 1'b0);
    op("R8", K_IDLE, 0, 1'b0, K_WR, 5, 1'b0);
    op("R8", K_IDLE, 0, 1'b0, K_WR, 5, 1'b1);
    op("R8", K_WR, 5, 1'b1, K_IDLE, 0, 1'b0); readBoth("R8", 5);

    // R6: release and request in the same cycle
    op("R6", K_WR, 4, 1'b0, K_IDLE, 0, 1'b0);
    op("R6", K_WR, 4, 1'b1, K_WR, 4, 1'b0); readBoth("R6", 4);
    op("R7", K_IDLE, 0, 1'b0, K_WR, 4, 1'b1); readBoth("R7", 4);

    // R9: simultaneous request on a free flag
    op("R9", K_WR, 6, 1'b0, K_WR, 6, 1'b0); readBoth("R9", 6);
    op("R9", K_WR, 6, 1'b1, K_IDLE, 0, 1'b0); readBoth("R9", 6);
    op("R9", K_IDLE, 0, 1'b0, K_WR, 6, 1'b1); readBoth("R9", 6);

    // R2: writes without a valid bank access are ignored
    op("R2", K_WR_MEM, 2, 1'b0, K_WR_NOSEL, 2, 1'b0); readBoth("R2", 2);
    op("R2", K_WR_NOSEL, 1, 1'b0, K_IDLE, 0, 1'b0); readBoth("R2", 1);

    // R11: repeat request by owner, release of a free flag
    op("R11", K_WR, 0, 1'b0, K_IDLE, 0, 1'b0);
    op("R11", K_WR, 0, 1'b0, K_WR, 7, 1'b1); readBoth("R11", 0); readBoth("R11", 7);

    // R10: neighbour untouched; R3 same-cycle read shows old state
    readBoth("R10", 1);
    op("R3", K_WR, 0, 1'b1, K_RD, 0, 1'b0); readBoth("R3", 0);

    // constrained random traffic on a narrow index set
    for (int i = 0; i < 4000; i++) begin
      int lk, rk, li, ri;
      lk = int'($urandom_range(0, 4)); rk = int'($urandom_range(0, 4));
      li = int'($urandom_range(0, 2)); ri = int'($urandom_range(0, 2));
      if ($urandom_range(0, 3) == 0) li = int'($urandom_range(0, NF - 1));
      op("R10", lk, li, 1'($urandom), rk, ri, 1'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule